// File: doc/BRIEF.md
# Triple 8-bit Modulo Timer with Cascade, PWM and Carrier Modes

The block holds three 8-bit up-counters. Each one advances on a count pulse that it takes from a shared set of prescaled tick strobes, and each one compares its count against its own modulo register. In the basic mode a channel clears its counter when the count equals the modulo value. On the same tick it toggles its output flip-flop and raises an interrupt request for one cycle.

Channels 1 and 2 can also work as a pair. The pair can form one 16-bit counter. Channel 2 can instead run alone as a free-running 256-count PWM generator. It can also act as a carrier generator: it alternates between a low-period and a high-period limit, and its output is gated by a data bit that channel 1 refreshes at every one of its matches.

The surrounding register file holds the mode and clock-select fields and the output enables, and presents them to the block as steady levels. Writes to the modulo registers, writes to the high-period register and the start/clear commands arrive as single-cycle strobes.

Top module: `tmr_trio`

## Requirements
- R1: In split mode, on a selected tick where a channel's count equals its modulo value, the counter becomes 0 and the channel's output flop toggles. `irq_o[n]` is high for exactly the following cycle. On any other tick the count rises by 1, so the period is modulo+1 ticks.
- R2: The field `csel_i[2n+1:2n]` chooses which bit of `tick_i` drives channel n (value v selects `tick_i[v]`). Pulses on the other bits of `tick_i` leave that channel unchanged.
- R3: With a modulo value of 0, the channel output toggles on every selected tick.
- R4: After reset, all counters are 0, all output flops are 0, the carrier data bit is 0, no interrupt is pending, and every modulo register and the high-period register hold FFH. The first toggle therefore comes on the 256th tick.
- R5: The pair mode comes from `{mode1_i, mode2_i}`: 00/00 gives split, 00/01 gives PWM on channel 2, 10/10 gives 16-bit cascade, and 00/11 gives carrier. Any other combination behaves as split.
- R6: In cascade, channel 1 is the low byte and channel 2 is the high byte, and both advance on channel 1's tick. When the 16-bit count equals {modulo2, modulo1}, both bytes clear, channel 1's flop toggles and `irq_o[1]` pulses. `irq_o[2]` stays low and channel 2's flop does not toggle.
- R7: In PWM mode, channel 2 counts 0..255 and wraps, ignoring its modulo value for the period. `tout_o[2]` is high while the count is below modulo2 and low otherwise. `irq_o[2]` pulses after the tick that wraps the count to 0.
- R8: In carrier mode, channel 2 compares against modulo2 while its flop is 0 and against the high-period register while its flop is 1. `tout_o[2]` equals the flop ANDed with the carrier data bit.
- R9: In carrier mode, each channel 1 match loads `nrz_buf_i` into the carrier data bit.
- R10: A `start_i[n]` strobe clears channel n's counter and flop, overrides a tick in the same cycle and suppresses that cycle's interrupt. In cascade, `start_i[1]` clears both bytes.
- R11: `tout_o[n]` is 0 whenever `oe_i[n]` is 0, and it shows the channel's output state when `oe_i[n]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 4 | Prescaled count strobes, one cycle wide |
| csel_i | input | 6 | Per-channel tick select, 2 bits per channel |
| mode1_i | input | 2 | Channel 1 mode field |
| mode2_i | input | 2 | Channel 2 mode field |
| mod_we_i | input | 3 | Modulo register write strobes, one per channel |
| hi_we_i | input | 1 | High-period register write strobe |
| wdata_i | input | 8 | Write data for the modulo and high-period registers |
| start_i | input | 3 | Per-channel start/clear strobes |
| oe_i | input | 3 | Per-channel output enables |
| nrz_buf_i | input | 1 | Next carrier data bit |
| tout_o | output | 3 | Timer outputs |
| irq_o | output | 3 | Interrupt request pulses |

## Verification
The assertions take every control input as synchronous to `clk`. They also take the mode fields as steady for at least one cycle around any interrupt they judge: the cascade and PWM checks compare each interrupt against the mode sampled one edge earlier. The stimulus changes modes, selects and enables only in cycles with no tick. It follows every mode change with a start strobe on all channels before it pulses any tick, so stale flop and count values never reach a check.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_PWM   = 2'd1,
    MODE_CASC  = 2'd2,
    MODE_CARR  = 2'd3
  } tmr_mode_e;

  function automatic tmr_mode_e tmr_decode(input logic [1:0] f1, input logic [1:0] f2);
    if (f1 == 2'b10 && f2 == 2'b10) return MODE_CASC;
    if (f1 == 2'b00 && f2 == 2'b01) return MODE_PWM;
    if (f1 == 2'b00 && f2 == 2'b11) return MODE_CARR;
    return MODE_SPLIT;
  endfunction
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int NTAP = 4,
  parameter int SELW = $clog2(NTAP)
) (
  input  logic [NTAP-1:0] taps_i,
  input  logic [SELW-1:0] sel_i,
  output logic            tick_o
);
  always_comb tick_o = taps_i[sel_i];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load0_i,
  input  logic         step_i,
  input  logic         tog_i,
  output logic [W-1:0] cnt_o,
  output logic         tff_o
);
  logic [W-1:0] cnt_d;
  logic         tff_d;
  logic         en;

  // next state: clear beats reload-to-zero beats step
  always_comb begin
    cnt_d = cnt_o;
    tff_d = tff_o;
    if (clr_i) begin
      cnt_d = '0;
      tff_d = 1'b0;
    end else begin
      if (load0_i)     cnt_d = '0;
      else if (step_i) cnt_d = cnt_o + 1'b1;
      if (tog_i)       tff_d = ~tff_o;
    end
    en = clr_i | load0_i | step_i | tog_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      tff_o <= 1'b0;
    end else if (en) begin
      cnt_o <= cnt_d;
      tff_o <= tff_d;
    end
  end
endmodule

// File: rtl/tmr_trio.sv
module tmr_trio
  import tmr_pkg::*;
#(
  parameter int W    = 8,
  parameter int NTAP = 4,
  parameter int SELW = $clog2(NTAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTAP-1:0]   tick_i,
  input  logic [3*SELW-1:0] csel_i,
  input  logic [1:0]        mode1_i,
  input  logic [1:0]        mode2_i,
  input  logic [2:0]        mod_we_i,
  input  logic              hi_we_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [2:0]        start_i,
  input  logic [2:0]        oe_i,
  input  logic              nrz_buf_i,
  output logic [2:0]        tout_o,
  output logic [2:0]        irq_o
);
  localparam int NCH = 3;

  tmr_mode_e               mode;
  logic                    casc, pwm, carr;
  logic [NCH-1:0]          tk, clr, step, load, tog;
  logic [W-1:0]            cnt_q [NCH];
  logic [NCH-1:0]          tff_q;
  logic [NCH-1:0][W-1:0]   modr_q;
  logic [W-1:0]            hi_q;
  logic                    nrz_q, nrz_d;
  logic [NCH-1:0]          irq_d;
  logic                    hit0, hit1, hit2, full16, carry, wrap2;
  logic [W-1:0]            cmp2;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    tmr_tick_sel #(.NTAP(NTAP), .SELW(SELW)) u_sel (
      .taps_i (tick_i),
      .sel_i  (csel_i[n*SELW +: SELW]),
      .tick_o (tk[n])
    );
    tmr_chan #(.W(W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr[n]),
      .load0_i (load[n]),
      .step_i  (step[n]),
      .tog_i   (tog[n]),
      .cnt_o   (cnt_q[n]),
      .tff_o   (tff_q[n])
    );
  end

  // compare and sequencing
  always_comb begin
    mode   = tmr_decode(mode1_i, mode2_i);
    casc   = (mode == MODE_CASC);
    pwm    = (mode == MODE_PWM);
    carr   = (mode == MODE_CARR);

    clr    = {start_i[2] | (casc & start_i[1]), start_i[1], start_i[0]};

    hit0   = tk[0] & (cnt_q[0] == modr_q[0]);
    full16 = ({cnt_q[2], cnt_q[1]} == {modr_q[2], modr_q[1]});
    hit1   = tk[1] & (casc ? full16 : (cnt_q[1] == modr_q[1]));
    carry  = casc & tk[1] & ~full16 & (&cnt_q[1]);
    cmp2   = (carr & tff_q[2]) ? hi_q : modr_q[2];
    hit2   = tk[2] & ~casc & ~pwm & (cnt_q[2] == cmp2);
    wrap2  = pwm & tk[2] & (&cnt_q[2]);

    step[0] = tk[0] & ~hit0;
    load[0] = hit0;
    tog[0]  = hit0;
    step[1] = tk[1] & ~hit1;
    load[1] = hit1;
    tog[1]  = hit1;
    step[2] = casc ? carry : (pwm ? tk[2] : (tk[2] & ~hit2));
    load[2] = casc ? hit1 : hit2;
    tog[2]  = hit2;

    irq_d  = {hit2 | wrap2, hit1, hit0} & ~clr;
    nrz_d  = (carr & hit1) ? nrz_buf_i : nrz_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modr_q <= '1;
      hi_q   <= '1;
      nrz_q  <= 1'b0;
      irq_o  <= '0;
    end else begin
      for (int n = 0; n < NCH; n++)
        if (mod_we_i[n]) modr_q[n] <= wdata_i;
      if (hi_we_i) hi_q <= wdata_i;
      nrz_q <= nrz_d;
      irq_o <= irq_d;
    end
  end

  always_comb begin
    tout_o[0] = oe_i[0] & tff_q[0];
    tout_o[1] = oe_i[1] & tff_q[1];
    if (pwm)       tout_o[2] = oe_i[2] & (cnt_q[2] < modr_q[2]);
    else if (carr) tout_o[2] = oe_i[2] & tff_q[2] & nrz_q;
    else           tout_o[2] = oe_i[2] & tff_q[2];
  end
endmodule

// File: rtl/tmr_trio_chk.sv
module tmr_trio_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   start_i,
  input logic [1:0]   mode1_i,
  input logic [1:0]   mode2_i,
  input logic [2:0]   irq_o,
  input logic [W-1:0] cnt0_i,
  input logic [W-1:0] cnt2_i,
  input logic         tff0_i
);
  // R1: an interrupt pulse coincides with a cleared counter
  a_r1_clear_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] |-> (cnt0_i == '0));

  // R1: an interrupt pulse coincides with a flop toggle
  a_r1_toggle_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] |-> (tff0_i != $past(tff0_i)));

  // R10: start clears count and flop and masks the interrupt
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i[0] |=> (cnt0_i == '0 && !tff0_i && !irq_o[0]));

  // R6: no channel 2 interrupt out of cascade operation
  a_r6_no_irq2_casc: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1_i == 2'b10 && mode2_i == 2'b10) |=> !irq_o[2]);

  // R7: PWM interrupt only at the wrap to zero
  a_r7_pwm_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode1_i == 2'b00 && mode2_i == 2'b01) && irq_o[2]) |-> (cnt2_i == '0));
endmodule

bind tmr_trio tmr_trio_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .mode1_i (mode1_i),
  .mode2_i (mode2_i),
  .irq_o   (irq_o),
  .cnt0_i  (cnt_q[0]),
  .cnt2_i  (cnt_q[2]),
  .tff0_i  (tff_q[0])
);

// File: tb/tmr_trio_tb.sv
module tmr_trio_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [3:0] tick_i = '0;
  logic [5:0] csel_i = '0;
  logic [1:0] mode1_i = '0, mode2_i = '0;
  logic [2:0] mod_we_i = '0;
  logic       hi_we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [2:0] start_i = '0;
  logic [2:0] oe_i = '0;
  logic       nrz_buf_i = 1'b0;
  logic [2:0] tout_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [2:0] tout;
    logic [2:0] irq;
    string      tag;
  } exp_t;
  exp_t sbq[$];
  exp_t mon_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_trio u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .csel_i(csel_i),
    .mode1_i(mode1_i), .mode2_i(mode2_i), .mod_we_i(mod_we_i),
    .hi_we_i(hi_we_i), .wdata_i(wdata_i), .start_i(start_i),
    .oe_i(oe_i), .nrz_buf_i(nrz_buf_i), .tout_o(tout_o), .irq_o(irq_o)
  );

  // monitor: compares the state registered at each edge
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      mon_e = sbq.pop_front();
      checks++;
      if (tout_o !== mon_e.tout || irq_o !== mon_e.irq) begin
        fails++;
        $display("FAIL %s: tout=%b irq=%b expected tout=%b irq=%b",
                 mon_e.tag, tout_o, irq_o, mon_e.tout, mon_e.irq);
      end
    end
  end

  // driver: one cycle of stimulus plus its expected result
  task automatic cyc(input logic [3:0] t, input logic [2:0] s,
                     input logic [2:0] et, input logic [2:0] ei, input string tag);
    exp_t e;
    @(negedge clk);
    tick_i = t; start_i = s; mod_we_i = '0; hi_we_i = 1'b0;
    e.tout = et; e.irq = ei; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    tick_i = '0; start_i = '0; mod_we_i = '0; hi_we_i = 1'b0;
  endtask

  task automatic wmod(input int ch, input logic [7:0] v);
    @(negedge clk);
    tick_i = '0; start_i = '0; hi_we_i = 1'b0;
    mod_we_i = 3'(1 << ch); wdata_i = v;
  endtask

  task automatic whi(input logic [7:0] v);
    @(negedge clk);
    tick_i = '0; start_i = '0; mod_we_i = '0;
    hi_we_i = 1'b1; wdata_i = v;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    oe_i = 3'b111;

    // R4: reset state and FFH modulo preset
    cyc(4'b0000, 3'b000, 3'b000, 3'b000, "R4 reset idle");
    for (int i = 0; i < 255; i++)
      cyc(4'b0001, 3'b000, 3'b000, 3'b000, "R4 no toggle before tick 256");
    cyc(4'b0001, 3'b000, 3'b111, 3'b111, "R4 toggle on tick 256");
    cyc(4'b0000, 3'b000, 3'b111, 3'b000, "R1 irq lasts one cycle");

    // R1/R3: modulo 2, 0 and 5 in split mode
    cyc(4'b0000, 3'b111, 3'b000, 3'b000, "R10 start clears all");
    wmod(0, 8'd2); wmod(1, 8'd0); wmod(2, 8'd5);
    cyc(4'b0001, 3'b000, 3'b010, 3'b010, "R3 mod0 toggles tick1");
    cyc(4'b0001, 3'b000, 3'b000, 3'b010, "R3 mod0 toggles tick2");
    cyc(4'b0001, 3'b000, 3'b011, 3'b011, "R1 mod2 match tick3");
    cyc(4'b0001, 3'b000, 3'b001, 3'b010, "R1 tick4");
    cyc(4'b0001, 3'b000, 3'b011, 3'b010, "R1 tick5");
    cyc(4'b0001, 3'b000, 3'b100, 3'b111, "R1 mod5 match tick6");
    cyc(4'b0000, 3'b000, 3'b100, 3'b000, "R1 quiet cycle");

    // R2: channel 0 on tap 1, others on tap 0
    idle(); csel_i = 6'b00_00_01;
    cyc(4'b0000, 3'b111, 3'b000, 3'b000, "R10 start");
    cyc(4'b0001, 3'b000, 3'b010, 3'b010, "R2 tap0 skips ch0");
    cyc(4'b0010, 3'b000, 3'b010, 3'b000, "R2 tap1 skips ch1");
    cyc(4'b0010, 3'b000, 3'b010, 3'b000, "R2 ch0 count 2");
    cyc(4'b0010, 3'b000, 3'b011, 3'b001, "R2 ch0 match on tap1");
    cyc(4'b0010, 3'b001, 3'b010, 3'b000, "R10 start beats tick");

    // R11: output enables
    idle(); oe_i = 3'b000;
    cyc(4'b0000, 3'b000, 3'b000, 3'b000, "R11 outputs disabled");
    idle(); oe_i = 3'b111;
    cyc(4'b0000, 3'b000, 3'b010, 3'b000, "R11 outputs enabled");

    // R5/R6: 16-bit cascade, limit 0x0100
    idle(); mode1_i = 2'b10; mode2_i = 2'b10;
    wmod(1, 8'd0); wmod(2, 8'd1);
    cyc(4'b0000, 3'b111, 3'b000, 3'b000, "R10 start cascade");
    for (int i = 0; i < 256; i++)
      cyc(4'b0001, 3'b000, 3'b000, 3'b000, "R6 cascade counting");
    cyc(4'b0001, 3'b000, 3'b010, 3'b010, "R6 cascade 16-bit match");

    // R5/R7: PWM with modulo 3
    idle(); mode1_i = 2'b00; mode2_i = 2'b01; csel_i = 6'b00_01_01;
    wmod(2, 8'd3);
    cyc(4'b0000, 3'b111, 3'b100, 3'b000, "R7 level high at count 0");
    cyc(4'b0001, 3'b000, 3'b100, 3'b000, "R7 count 1 high");
    cyc(4'b0001, 3'b000, 3'b100, 3'b000, "R7 count 2 high");
    for (int i = 0; i < 253; i++)
      cyc(4'b0001, 3'b000, 3'b000, 3'b000, "R7 count at or above modulo low");
    cyc(4'b0001, 3'b000, 3'b100, 3'b100, "R7 wrap after 256 counts");

    // R5/R8/R9: carrier, low 2 ticks, high 3 ticks
    idle(); mode2_i = 2'b11;
    wmod(1, 8'd0); wmod(2, 8'd1); whi(8'd2);
    cyc(4'b0000, 3'b111, 3'b000, 3'b000, "R10 start carrier");
    idle(); nrz_buf_i = 1'b1;
    cyc(4'b0010, 3'b000, 3'b010, 3'b010, "R9 ch1 match loads data bit");
    cyc(4'b0001, 3'b000, 3'b010, 3'b000, "R8 low phase count");
    cyc(4'b0001, 3'b000, 3'b110, 3'b100, "R8 low limit reached");
    cyc(4'b0001, 3'b000, 3'b110, 3'b000, "R8 high phase 1");
    cyc(4'b0001, 3'b000, 3'b110, 3'b000, "R8 high phase 2");
    cyc(4'b0001, 3'b000, 3'b010, 3'b100, "R8 high limit reached");
    cyc(4'b0001, 3'b000, 3'b010, 3'b000, "R8 low phase again");
    cyc(4'b0001, 3'b000, 3'b110, 3'b100, "R8 high phase again");
    idle(); nrz_buf_i = 1'b0;
    cyc(4'b0010, 3'b000, 3'b000, 3'b010, "R9 data bit cleared gates carrier");
    cyc(4'b0000, 3'b000, 3'b000, 3'b000, "R8 gated output stays low");

    idle();
    idle();
    done = 1'b1;
    report();
  end
endmodule